// File: doc/BRIEF.md
# Sequenced Three-Timer Group with Shared Prescaler

This block holds three 16-bit counters: one core counter and two auxiliary counters, A and B. A shared prescaler turns the system clock into a slower basic clock, whose period is set by a 2-bit code. Inside each basic clock a small sequencer visits the counters one at a time, in a fixed order of slots. Each counter also has its own 3-bit divider, which lets it advance only once every 2^n basic clocks.

When the core counter wraps, it can take a new start value from either auxiliary counter. Auxiliary A can instead act as the upper 16 bits of a 32-bit count: it steps whenever the core counter wraps. A strobe input can copy the core value into auxiliary A.

Software reaches all three counters and two control words through one write port and one read port. Three direction inputs choose up or down counting for each counter. Each counter has an interrupt output that gives a one-cycle pulse when it wraps.

Top module: `tmr_group`

Address map: 0 = core count, 1 = aux A, 2 = aux B, 3 = control word 0, 4 = control word 1.

Control word 0 bits:

| Bits | Field |
|---|---|
| [1:0] | basic-clock code |
| [4:2] | core divider n |
| [7:5] | aux A divider n |
| [10:8] | aux B divider n |
| [11] | core run |
| [12] | aux A run |
| [13] | aux B run |
| [15:14] | reload source: 00 none, 01 aux A, 10 aux B |

Control word 1 bits:

| Bit | Field |
|---|---|
| [0] | aux A chained as the upper half |
| [1] | capture enable |

## Requirements
- R1: A synchronous active-high reset clears all three counters, both control words and all three interrupt outputs to zero.
- R2: The basic-clock code in control word 0 bits [1:0] sets the basic-clock period in system clocks: 01 gives 4, 00 gives 8, 11 gives 16 and 10 gives 32. After a write to control word 0, a running core counter with divider 0 steps on the next clock edge, and then once every period.
- R3: The divider field n of a counter (0 to 7) makes that counter step only on every 2^n-th slot visit. The first step comes on the 2^n-th visit after a write to control word 0.
- R4: Counting up from FFFFh gives 0000h, and counting down from 0000h gives FFFFh. Each such wrap raises that counter's interrupt output for exactly one cycle.
- R5: If the reload source is 01 (aux A) or 10 (aux B), a core wrap loads the selected auxiliary value into the core counter on the same edge as the wrap. The wrap value 0000h or FFFFh is never visible.
- R6: When control word 1 bit 0 is set, aux A adds 1 after each core overflow and subtracts 1 after each core underflow. This update completes within the same basic clock as the core wrap.
- R7: Within each basic clock, the core counter is served in slot 0, aux A in slot 1, aux B in slot 2 and the capture in slot 3. Each slot lasts period/4 system clocks for code 01 and period/8 for the other codes, so slot k starts k×slot-length clocks after slot 0.
- R8: A pulse on `cap_strobe` is held pending until the next slot 3. In that slot, aux A takes the core value if control word 1 bit 1 is set. If that bit is clear, aux A is left unchanged.
- R9: A software write to a counter wins over a hardware update on the same edge. Every register reads back on `rd_data` in the same cycle. Writing control word 0 restarts the slot sequence and clears the dividers.
- R10: Each counter counts down while its direction input (`core_down`, `auxa_down`, `auxb_down`) is high, and up while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| core_down | input | 1 | Core counter direction (1 = down) |
| auxa_down | input | 1 | Aux A direction (1 = down) |
| auxb_down | input | 1 | Aux B direction (1 = down) |
| cap_strobe | input | 1 | Capture request |
| irq_core | output | 1 | Core wrap pulse |
| irq_auxa | output | 1 | Aux A wrap pulse |
| irq_auxb | output | 1 | Aux B wrap pulse |

## Verification
Every result is timed from the edge E0 on which control word 0 is written. Core steps land on E0+1 and then every period. Aux A steps land one slot later, aux B steps two slots later, and captures three slots later; a slot is 1, 2 or 4 clocks depending on the code. Interrupts are high for the single cycle after the updating edge. The bench counts edges from E0 and samples 2 ns after the edge on which each result is due, with the read address set before the sample. For the slot-order checks, it also samples one edge early to confirm that the value has not yet moved.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W = 16;
    localparam int PRE_W = 3;
    localparam int SEQ_W = 5;
    localparam int SLOTS = 4;

    typedef enum logic [1:0] {
        RL_NONE = 2'b00,
        RL_AUXA = 2'b01,
        RL_AUXB = 2'b10,
        RL_RSVD = 2'b11
    } reload_sel_e;

    typedef enum logic [2:0] {
        REG_CORE  = 3'd0,
        REG_AUXA  = 3'd1,
        REG_AUXB  = 3'd2,
        REG_CTRL0 = 3'd3,
        REG_CTRL1 = 3'd4
    } reg_addr_e;

    typedef struct packed {
        reload_sel_e        rl;
        logic               run_b;
        logic               run_a;
        logic               run_c;
        logic [PRE_W-1:0]   pre_b;
        logic [PRE_W-1:0]   pre_a;
        logic [PRE_W-1:0]   pre_c;
        logic [1:0]         bps;
    } ctrl0_t;

    typedef struct packed {
        logic cap_en;
        logic concat;
    } ctrl1_t;

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             wrap;
    } step_t;

    function automatic int period_of(input logic [1:0] code);
        case (code)
            2'b01:   return 4;
            2'b00:   return 8;
            2'b11:   return 16;
            default: return 32;
        endcase
    endfunction

    function automatic int slot_len(input logic [1:0] code);
        case (code)
            2'b01, 2'b00: return 1;
            2'b11:        return 2;
            default:      return 4;
        endcase
    endfunction

    function automatic step_t count_step(input logic [CNT_W-1:0] v, input logic down);
        step_t r;
        if (down) begin
            r.val  = v - 1'b1;
            r.wrap = (v == '0);
        end else begin
            r.val  = v + 1'b1;
            r.wrap = (v == '1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_seq.sv
module tmr_seq
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [1:0]       bps,
    output logic [SLOTS-1:0] act
);
    logic [SEQ_W-1:0] pcnt;
    logic [SEQ_W-1:0] last;

    assign last = SEQ_W'(period_of(bps) - 1);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pcnt <= '0;
        else if (pcnt == last)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign act[k] = !restart && (pcnt == SEQ_W'(k * slot_len(bps)));
    end
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc
    import tmr_pkg::*;
#(
    parameter int SW = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int CW = (1 << SW) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;

    assign mask = CW'((32'd1 << sel) - 32'd1);
    assign tick = adv && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             core_down,
    input  logic             auxa_down,
    input  logic             auxb_down,
    input  logic             cap_strobe,
    output logic             irq_core,
    output logic             irq_auxa,
    output logic             irq_auxb
);
    localparam int NT = 3;

    ctrl0_t           c0;
    ctrl1_t           c1;
    logic [CNT_W-1:0] core_q, auxa_q, auxb_q, core_nxt;
    logic             pend_up, pend_dn, cap_pend;
    logic [SLOTS-1:0] act;
    logic [NT-1:0]    adv, tick;
    logic [PRE_W-1:0] pre_sel [NT];
    logic             wr_core, wr_auxa, wr_auxb, wr_c0, wr_c1, a_evt;
    step_t            cs, as_s, bs_s;

    assign wr_core = wr_en && (wr_addr == REG_CORE);
    assign wr_auxa = wr_en && (wr_addr == REG_AUXA);
    assign wr_auxb = wr_en && (wr_addr == REG_AUXB);
    assign wr_c0   = wr_en && (wr_addr == REG_CTRL0);
    assign wr_c1   = wr_en && (wr_addr == REG_CTRL1);

    tmr_seq i_seq (
        .clk(clk), .rst(rst), .restart(wr_c0), .bps(c0.bps), .act(act)
    );

    assign adv[0]     = act[0] && c0.run_c;
    assign adv[1]     = act[1] && c0.run_a && !c1.concat;
    assign adv[2]     = act[2] && c0.run_b;
    assign pre_sel[0] = c0.pre_c;
    assign pre_sel[1] = c0.pre_a;
    assign pre_sel[2] = c0.pre_b;

    for (genvar i = 0; i < NT; i++) begin : g_pre
        tmr_presc #(.SW(PRE_W)) i_presc (
            .clk(clk), .rst(rst), .clr(wr_c0),
            .adv(adv[i]), .sel(pre_sel[i]), .tick(tick[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c0 <= '0;
            c1 <= '0;
        end else begin
            if (wr_c0) c0 <= ctrl0_t'(wr_data);
            if (wr_c1) c1 <= ctrl1_t'(wr_data[1:0]);
        end
    end

    // core counter, slot 0, with reload on wrap
    always_comb begin
        cs       = count_step(core_q, core_down);
        core_nxt = cs.val;
        if (cs.wrap && c0.rl == RL_AUXA) core_nxt = auxa_q;
        if (cs.wrap && c0.rl == RL_AUXB) core_nxt = auxb_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q   <= '0;
            irq_core <= 1'b0;
            pend_up  <= 1'b0;
            pend_dn  <= 1'b0;
        end else begin
            irq_core <= 1'b0;
            if (act[1]) begin
                pend_up <= 1'b0;
                pend_dn <= 1'b0;
            end
            if (wr_core) begin
                core_q <= wr_data;
            end else if (tick[0]) begin
                core_q <= core_nxt;
                if (cs.wrap) begin
                    irq_core <= 1'b1;
                    if (c1.concat) begin
                        pend_up <= !core_down;
                        pend_dn <= core_down;
                    end
                end
            end
        end
    end

    // aux A: slot 1 for counting or chained step, slot 3 for capture
    assign as_s  = count_step(auxa_q, c1.concat ? pend_dn : auxa_down);
    assign a_evt = c1.concat ? (act[1] && (pend_up || pend_dn)) : tick[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            auxa_q   <= '0;
            irq_auxa <= 1'b0;
            cap_pend <= 1'b0;
        end else begin
            irq_auxa <= 1'b0;
            if (cap_strobe)
                cap_pend <= 1'b1;
            else if (act[3])
                cap_pend <= 1'b0;
            if (wr_auxa) begin
                auxa_q <= wr_data;
            end else if (a_evt) begin
                auxa_q   <= as_s.val;
                irq_auxa <= as_s.wrap;
            end else if (act[3] && c1.cap_en && cap_pend) begin
                auxa_q <= core_q;
            end
        end
    end

    // aux B: slot 2
    assign bs_s = count_step(auxb_q, auxb_down);

    always_ff @(posedge clk) begin
        if (rst) begin
            auxb_q   <= '0;
            irq_auxb <= 1'b0;
        end else begin
            irq_auxb <= 1'b0;
            if (wr_auxb) begin
                auxb_q <= wr_data;
            end else if (tick[2]) begin
                auxb_q   <= bs_s.val;
                irq_auxb <= bs_s.wrap;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            REG_CORE:  rd_data = core_q;
            REG_AUXA:  rd_data = auxa_q;
            REG_AUXB:  rd_data = auxb_q;
            REG_CTRL0: rd_data = c0;
            REG_CTRL1: rd_data = {{(CNT_W-2){1'b0}}, c1};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] core_q,
    input logic [CNT_W-1:0] auxa_q,
    input logic [CNT_W-1:0] auxb_q,
    input logic [SLOTS-1:0] act,
    input ctrl0_t           c0,
    input logic             irq_core,
    input logic             irq_auxa,
    input logic             irq_auxb
);
    a_r4_irq_core_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_core |=> !irq_core);

    a_r4_irq_auxa_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_auxa |=> !irq_auxa);

    a_r4_irq_auxb_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_auxb |=> !irq_auxb);

    a_r5_reload_from_a: assert property (@(posedge clk) disable iff (rst)
        (irq_core && !$past(rst) && !$past(wr_en) && $past(c0.rl) == RL_AUXA)
        |-> core_q == $past(auxa_q));

    a_r7_core_slot: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(core_q))
        |-> ($past(act[0]) || ($past(wr_en) && $past(wr_addr) == REG_CORE)));

    a_r7_auxb_slot: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(auxb_q))
        |-> ($past(act[2]) || ($past(wr_en) && $past(wr_addr) == REG_AUXB)));
endmodule

bind tmr_group tmr_group_chk i_chk (.*);

// File: tb/test_tmr_group.sv
module test_tmr_group;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        core_down = 1'b0, auxa_down = 1'b0, auxb_down = 1'b0;
    logic        cap_strobe = 1'b0;
    logic        irq_core, irq_auxa, irq_auxb;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tmr_group i_tmr_group (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .core_down(core_down),
        .auxa_down(auxa_down), .auxb_down(auxb_down), .cap_strobe(cap_strobe),
        .irq_core(irq_core), .irq_auxa(irq_auxa), .irq_auxb(irq_auxb)
    );

    // vector: {bps[1:0], n[2:0], down, start[15:0], edges[7:0]}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {2'b01, 3'd0, 1'b0, 16'h0000, 8'd1},
        {2'b01, 3'd0, 1'b0, 16'h0000, 8'd9},
        {2'b00, 3'd0, 1'b0, 16'h0000, 8'd17},
        {2'b11, 3'd0, 1'b0, 16'h0000, 8'd33},
        {2'b10, 3'd0, 1'b0, 16'h0000, 8'd65},
        {2'b01, 3'd2, 1'b0, 16'h0000, 8'd29},
        {2'b01, 3'd0, 1'b1, 16'h0005, 8'd9},
        {2'b01, 3'd0, 1'b0, 16'hFFFE, 8'd5},
        {2'b01, 3'd0, 1'b1, 16'h0001, 8'd5},
        {2'b01, 3'd1, 1'b0, 16'h0000, 8'd8}
    };

    function automatic int per(input logic [1:0] code);
        case (code)
            2'b01: return 4;
            2'b00: return 8;
            2'b11: return 16;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        core_down = 1'b0; auxa_down = 1'b0; auxb_down = 1'b0; cap_strobe = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        edges(3);
        #1 rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 16'h0000);
        end
        chk("R1 reset irq", {13'd0, irq_core, irq_auxa, irq_auxb}, 16'h0000);

        // R2 R3 R4 R10 vector table
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  b;
            logic [2:0]  n;
            logic        dn;
            logic [15:0] st, ex;
            int          c, acts, ticks;
            {b, n, dn, st} = VEC[i][29:8];
            c = int'(VEC[i][7:0]);
            acts  = (c >= 1) ? (c - 1) / per(b) + 1 : 0;
            ticks = acts >> n;
            ex    = dn ? st - 16'(ticks) : st + 16'(ticks);
            do_reset();
            core_down = dn;
            wr(3'd0, st);
            wr(3'd3, {2'b00, 3'b001, 3'd0, 3'd0, n, b});
            edges(c);
            rd(3'd0, v);
            chk($sformatf("R2 R3 R4 R10 vector %0d", i), v, ex);
        end

        // R4 overflow pulse
        do_reset();
        wr(3'd0, 16'hFFFF);
        wr(3'd3, 16'h0801);
        edges(1);
        rd(3'd0, v);
        chk("R4 wrap value", v, 16'h0000);
        chk("R4 irq_core high", {15'd0, irq_core}, 16'd1);
        edges(1);
        chk("R4 irq_core one cycle", {15'd0, irq_core}, 16'd0);

        // R5 reload from aux A, counting up
        do_reset();
        wr(3'd1, 16'h1234);
        wr(3'd0, 16'hFFFF);
        wr(3'd3, 16'h4801);
        edges(1);
        rd(3'd0, v);
        chk("R5 reload from A, no 0000", v, 16'h1234);

        // R5 reload from aux B, counting down
        do_reset();
        core_down = 1'b1;
        wr(3'd2, 16'h00F0);
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h8801);
        edges(1);
        rd(3'd0, v);
        chk("R5 reload from B", v, 16'h00F0);
        chk("R5 R4 underflow irq", {15'd0, irq_core}, 16'd1);

        // R6 R7 chained overflow, code 00, slot length 1
        do_reset();
        wr(3'd4, 16'h0001);
        wr(3'd1, 16'h0005);
        wr(3'd0, 16'hFFFF);
        wr(3'd3, 16'h0800);
        edges(1);
        rd(3'd1, v);
        chk("R7 aux A not before its slot", v, 16'h0005);
        edges(1);
        rd(3'd1, v);
        chk("R6 chained increment", v, 16'h0006);

        // R6 R7 chained underflow, code 11, slot length 2
        do_reset();
        core_down = 1'b1;
        wr(3'd4, 16'h0001);
        wr(3'd3, 16'h0803);
        edges(2);
        rd(3'd1, v);
        chk("R7 aux A waits two clocks", v, 16'h0000);
        edges(1);
        rd(3'd1, v);
        chk("R6 chained decrement", v, 16'hFFFF);
        chk("R6 R4 aux A wrap irq", {15'd0, irq_auxa}, 16'd1);
        edges(1);
        chk("R4 irq_auxa one cycle", {15'd0, irq_auxa}, 16'd0);

        // R7 R10 aux B in slot 2, counting down
        do_reset();
        auxb_down = 1'b1;
        wr(3'd3, 16'h2001);
        edges(2);
        rd(3'd2, v);
        chk("R7 aux B not before slot 2", v, 16'h0000);
        edges(1);
        rd(3'd2, v);
        chk("R7 R10 aux B down step", v, 16'hFFFF);
        chk("R4 irq_auxb", {15'd0, irq_auxb}, 16'd1);

        // R8 capture enabled
        do_reset();
        wr(3'd4, 16'h0002);
        wr(3'd1, 16'h1111);
        wr(3'd0, 16'h0ABC);
        wr(3'd3, 16'h0001);
        @(negedge clk);
        cap_strobe = 1'b1;
        @(posedge clk);
        #1 cap_strobe = 1'b0;
        edges(2);
        rd(3'd1, v);
        chk("R8 capture waits for slot 3", v, 16'h1111);
        edges(1);
        rd(3'd1, v);
        chk("R8 capture copies core", v, 16'h0ABC);

        // R8 capture disabled
        do_reset();
        wr(3'd1, 16'h1111);
        wr(3'd0, 16'h0ABC);
        wr(3'd3, 16'h0001);
        @(negedge clk);
        cap_strobe = 1'b1;
        @(posedge clk);
        #1 cap_strobe = 1'b0;
        edges(8);
        rd(3'd1, v);
        chk("R8 capture disabled ignored", v, 16'h1111);

        // R9 write priority and read-back
        do_reset();
        wr(3'd3, 16'h0801);
        wr(3'd0, 16'h4000);
        rd(3'd0, v);
        chk("R9 write wins over step", v, 16'h4000);
        edges(4);
        rd(3'd0, v);
        chk("R9 counting resumes", v, 16'h4001);
        rd(3'd3, v);
        chk("R9 control 0 read-back", v, 16'h0801);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule